// File: doc/BRIEF.md
# I2C Master Transfer Engine with Chained Repeated Start

This block runs whole I2C transfers as a bus master. A command interface presents a 7-bit target address, a byte count, a direction bit and a one-cycle start pulse. The engine then produces the start condition, the address byte, the data bytes and the closing stop on open-drain style controls. A control value of 1 pulls the line low and 0 releases it. SDA is read back through a separate input. Write bytes come from a first-word-fall-through transmit queue through a pop strobe. Read bytes leave as one-cycle pushes toward a receive queue. An external strobe, `tick_i`, paces every bus phase. The SCL timing generator that produces it, and bus arbitration, sit outside this block.

A write can be chained to a following read without a stop. While the write is in progress, software re-arms the command: it raises the start pulse again with direction set to read and a nonzero count. When the final written byte is acknowledged, the engine sees the pending command and takes the repeated-start branch. Otherwise it takes the stop branch. The states are IDLE, START (SDA low with SCL high), BIT_LO/BIT_HI (the two halves of a data or address bit), ACK_LO/ACK_HI (the acknowledge slot), WAIT (SCL held low until a transmit byte exists), RS_LO/RS_HI (SDA released ahead of a repeated start), and STOP_LO/STOP_HI. The transitions are as follows. IDLE→START on a captured command. START→BIT_LO. BIT_HI→BIT_LO, or BIT_HI→ACK_LO after the eighth bit. ACK_HI leads to BIT_LO (the next read byte), WAIT (the next write byte), RS_LO (chain) or STOP_LO (end, NACK or error). WAIT→BIT_LO on a popped byte. RS_LO→RS_HI→START. STOP_LO→STOP_HI→IDLE.

Top module: `i2cx_master`

## Requirements
- R1: After reset, both line controls are released (0), `ta_o`, `done_o`, `err_o`, `tx_pop_o` and `rx_valid_o` are 0.
- R2: Direction, length and address are sampled only when a command is taken; changing `cfg_*` afterwards does not alter the running phase (byte count, direction or address byte).
- R3: The address byte is the 7-bit address followed by the direction bit (1 = read), sent MSB first, as are written data bytes.
- R4: `ta_o` is 1 from the cycle after a command is taken in IDLE until the stop condition completes.
- R5: The start command clears itself when taken: one pulse of `go_i` yields exactly one transfer.
- R6: A NACK on the address byte sets `err_o` and ends the transfer with a stop; no data byte is popped.
- R7: A NACK on a written data byte sets `err_o` and is followed by a stop; later bytes stay unpopped.
- R8: While write bytes remain and the transmit queue is empty, SCL is held low and nothing is popped; `tx_pop_o` is raised only while `tx_valid_i` is 1.
- R9: When the last written byte is acknowledged and a start command is pending (including a `go_i` pulse in that very cycle) with read selected and a nonzero length, the engine issues a repeated start with no stop. It then addresses the current `cfg_addr_i` with the read bit set and reads that many bytes.
- R10: If no command is pending at the end of a write, or the pending one is a write, a stop is issued; a still-pending command then starts a fresh transfer from IDLE.
- R11: A read acknowledges every byte but the last, NACKs the last, then stops; each byte appears once on `rx_data_o` with `rx_valid_o` high.
- R12: `done_o` rises only when the final phase's stop completes, never at a repeated start; `done_o` and `err_o` clear when the next transfer is taken from IDLE.
- R13: Outside IDLE, the bus controls do not change in a cycle where `tick_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Bus phase advance strobe |
| go_i | input | 1 | Start command pulse |
| cfg_addr_i | input | 7 | Target address |
| cfg_read_i | input | 1 | Direction, 1 = read |
| cfg_len_i | input | LEN_W | Byte count |
| tx_data_i | input | 8 | Head of transmit queue |
| tx_valid_i | input | 1 | Transmit queue not empty |
| tx_pop_o | output | 1 | Consume transmit head |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte push |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | Sampled SDA line |
| ta_o | output | 1 | Transfer active |
| done_o | output | 1 | Transfer finished |
| err_o | output | 1 | NACK seen |

## Verification
Two events can fall in the same cycle here: the decision taken on the acknowledge of the last written byte, and a fresh start pulse arriving. The bench counts SCL rising edges with the phase strobe held high, so it knows the exact cycle the engine sits in the final acknowledge slot. It raises `go_i` in that cycle in one run, and one cycle later in another. The first run must show a repeated start followed by a read with no stop in between. The second must show a stop, then a separate read transfer started from IDLE by the still-pending command.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_BLO, ST_BHI, ST_ALO, ST_AHI,
        ST_WAIT, ST_RLO, ST_RHI, ST_PLO, ST_PHI
    } bus_st_t;

    typedef enum logic [1:0] {
        K_ADDR, K_WR, K_RD
    } kind_t;
endpackage

// File: rtl/i2cx_cmd.sv
module i2cx_cmd import i2cx_pkg::*; #(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic              cfg_read_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    input  logic              take_i,
    output logic              pend_o,
    output logic              rearm_ok_o,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic              read_q_o
);
    logic start_q;

    assign pend_o     = start_q | go_i;
    assign rearm_ok_o = pend_o & cfg_read_i & (cfg_len_i != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            addr_q_o <= '0;
            read_q_o <= 1'b0;
        end else begin
            start_q <= pend_o & ~take_i;
            if (take_i) begin
                addr_q_o <= cfg_addr_i;
                read_q_o <= cfg_read_i;
            end
        end
    end

    // R5: the engine only takes a command that is actually pending
    p_take_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pend_o);
endmodule

// File: rtl/i2cx_shift.sv
module i2cx_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    input  logic          step_i,
    input  logic          sin_i,
    output logic          msb_o,
    output logic          last_o,
    output logic [DW-1:0] data_o
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] sh;
    logic [CW-1:0] bc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
            bc <= '0;
        end else if (load_i) begin
            sh <= load_val_i;
            bc <= '0;
        end else if (step_i) begin
            sh <= {sh[DW-2:0], sin_i};
            bc <= bc + 1'b1;
        end
    end

    assign msb_o  = sh[DW-1];
    assign last_o = (bc == CW'(DW-1));
    assign data_o = sh;
endmodule

// File: rtl/i2cx_master.sv
module i2cx_master import i2cx_pkg::*; #(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic              cfg_read_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_pop_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    input  logic              sda_i,
    output logic              ta_o,
    output logic              done_o,
    output logic              err_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    bus_st_t st, st_n;
    kind_t   kind, kind_n;
    logic [LEN_W-1:0] cnt;

    logic pend, rearm_ok, take, cur_read;
    logic [ADDR_W-1:0] cur_addr;
    logic ld, step, sh_msb, sh_last, wr_fin;
    logic [BYTE_W-1:0] ld_val;
    logic cnt_ld, cnt_dec, e_set, d_set;

    i2cx_cmd #(.LEN_W(LEN_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .go_i(go_i),
        .cfg_addr_i(cfg_addr_i), .cfg_read_i(cfg_read_i), .cfg_len_i(cfg_len_i),
        .take_i(take), .pend_o(pend), .rearm_ok_o(rearm_ok),
        .addr_q_o(cur_addr), .read_q_o(cur_read)
    );

    i2cx_shift #(.DW(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(ld), .load_val_i(ld_val),
        .step_i(step), .sin_i(sda_i), .msb_o(sh_msb), .last_o(sh_last),
        .data_o(rx_data_o)
    );

    // next state and control strobes
    always_comb begin
        st_n = st; kind_n = kind;
        take = 1'b0; ld = 1'b0; ld_val = '0; step = 1'b0;
        tx_pop_o = 1'b0; rx_valid_o = 1'b0;
        e_set = 1'b0; d_set = 1'b0; cnt_ld = 1'b0; cnt_dec = 1'b0;
        wr_fin = 1'b0;
        unique case (st)
            ST_IDLE: if (pend) begin
                take = 1'b1; cnt_ld = 1'b1; st_n = ST_START;
            end
            ST_START: if (tick_i) begin
                ld = 1'b1; ld_val = {cur_addr, cur_read};
                kind_n = K_ADDR; st_n = ST_BLO;
            end
            ST_BLO: if (tick_i) st_n = ST_BHI;
            ST_BHI: if (tick_i) begin
                step = 1'b1;
                st_n = sh_last ? ST_ALO : ST_BLO;
            end
            ST_ALO: if (tick_i) st_n = ST_AHI;
            ST_AHI: if (tick_i) begin
                unique case (kind)
                    K_ADDR: begin
                        if (sda_i) begin
                            e_set = 1'b1; st_n = ST_PLO;
                        end else if (cur_read) begin
                            if (cnt == '0) st_n = ST_PLO;
                            else begin
                                kind_n = K_RD; ld = 1'b1; st_n = ST_BLO;
                            end
                        end else if (cnt == '0) wr_fin = 1'b1;
                        else begin
                            kind_n = K_WR; st_n = ST_WAIT;
                        end
                    end
                    K_WR: begin
                        cnt_dec = 1'b1;
                        if (sda_i) begin
                            e_set = 1'b1; st_n = ST_PLO;
                        end else if (cnt == ONE) wr_fin = 1'b1;
                        else st_n = ST_WAIT;
                    end
                    K_RD: begin
                        rx_valid_o = 1'b1; cnt_dec = 1'b1;
                        if (cnt == ONE) st_n = ST_PLO;
                        else begin
                            ld = 1'b1; st_n = ST_BLO;
                        end
                    end
                    default: st_n = ST_PLO;
                endcase
                if (wr_fin) begin
                    if (rearm_ok) begin
                        take = 1'b1; cnt_ld = 1'b1; st_n = ST_RLO;
                    end else st_n = ST_PLO;
                end
            end
            ST_WAIT: if (tick_i && tx_valid_i) begin
                tx_pop_o = 1'b1; ld = 1'b1; ld_val = tx_data_i; st_n = ST_BLO;
            end
            ST_RLO: if (tick_i) st_n = ST_RHI;
            ST_RHI: if (tick_i) st_n = ST_START;
            ST_PLO: if (tick_i) st_n = ST_PHI;
            ST_PHI: if (tick_i) begin
                d_set = 1'b1; st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register, counter and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE; kind <= K_ADDR; cnt <= '0;
            done_o <= 1'b0; err_o <= 1'b0;
        end else begin
            st <= st_n; kind <= kind_n;
            if (cnt_ld) cnt <= cfg_len_i;
            else if (cnt_dec) cnt <= cnt - ONE;
            if (st == ST_IDLE && take) begin
                done_o <= 1'b0; err_o <= 1'b0;
            end else begin
                if (e_set) err_o <= 1'b1;
                if (d_set) done_o <= 1'b1;
            end
        end
    end

    // bus line controls per state
    always_comb begin
        scl_oe_o = 1'b0; sda_oe_o = 1'b0;
        unique case (st)
            ST_IDLE, ST_RHI: ;
            ST_START: sda_oe_o = 1'b1;
            ST_BLO: begin
                scl_oe_o = 1'b1; sda_oe_o = (kind != K_RD) && !sh_msb;
            end
            ST_BHI: sda_oe_o = (kind != K_RD) && !sh_msb;
            ST_ALO: begin
                scl_oe_o = 1'b1; sda_oe_o = (kind == K_RD) && (cnt != ONE);
            end
            ST_AHI: sda_oe_o = (kind == K_RD) && (cnt != ONE);
            ST_WAIT, ST_RLO: scl_oe_o = 1'b1;
            ST_PLO: begin
                scl_oe_o = 1'b1; sda_oe_o = 1'b1;
            end
            ST_PHI: sda_oe_o = 1'b1;
            default: ;
        endcase
    end

    assign ta_o = (st != ST_IDLE);

    p_ta_after_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ta_o && go_i) |=> ta_o);
    p_tick_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_o && !tick_i) |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));
    p_pop_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |-> tx_valid_i);
    p_err_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (st == ST_PLO));
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !ta_o);
    p_rx_lowclk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> scl_oe_o);
endmodule

// File: tb/sim_i2cx_master.sv
`timescale 1ns/1ps
module sim_i2cx_master;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b1;
    logic go_i = 1'b0;
    logic [6:0] cfg_addr_i = 7'h2A;
    logic cfg_read_i = 1'b0;
    logic [7:0] cfg_len_i = 8'd0;
    logic [7:0] tx_data_i;
    logic tx_valid_i, tx_pop_o, rx_valid_o, scl_oe_o, sda_oe_o, sda_i;
    logic ta_o, done_o, err_o;
    logic [7:0] rx_data_o;

    always #4 clk = ~clk;

    // transmit queue model
    logic [7:0] tx_mem [0:15];
    logic [4:0] wr = 5'd0;
    logic [4:0] rd = 5'd0;
    assign tx_valid_i = (wr != rd);
    assign tx_data_i  = tx_mem[rd[3:0]];
    always @(posedge clk) if (tx_pop_o) rd <= rd + 5'd1;

    // slave model drive
    logic sl_low = 1'b0;
    assign sda_i = ~(sda_oe_o | sl_low);

    i2cx_master #(.LEN_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .go_i(go_i),
        .cfg_addr_i(cfg_addr_i), .cfg_read_i(cfg_read_i), .cfg_len_i(cfg_len_i),
        .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_pop_o(tx_pop_o),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .sda_i(sda_i),
        .ta_o(ta_o), .done_o(done_o), .err_o(err_o)
    );

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rxe_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // slave bus monitor and responder
    int n_start = 0, n_rstart = 0, n_stop = 0, n_rise = 0;
    int n_mack = 0, n_mnack = 0;
    bit ack_addr = 1'b1, ack_data = 1'b1;
    bit rs_done = 1'b0;
    int mode = 0;
    int sl_bit = 0;
    int rd_idx = 0;
    bit sl_open = 1'b0;
    logic [7:0] sl_sh = 8'h00;
    logic scl_p = 1'b1, sda_p = 1'b1;

    always @(negedge clk) begin
        logic scl_v, sda_v;
        logic [7:0] rb;
        scl_v = ~scl_oe_o;
        sda_v = ~(sda_oe_o | sl_low);
        if (scl_v && scl_p && sda_p && !sda_v) begin
            n_start++;
            if (sl_open) begin
                n_rstart++;
                if (done_o) rs_done = 1'b1;
            end
            sl_open = 1'b1; mode = 1; sl_bit = 0;
        end else if (scl_v && scl_p && !sda_p && sda_v) begin
            n_stop++; sl_open = 1'b0; mode = 0;
        end else if (scl_v && !scl_p) begin
            n_rise++;
            if (sl_bit < 8) begin
                if (mode == 1 || mode == 2) sl_sh = {sl_sh[6:0], sda_v};
                sl_bit++;
                if (sl_bit == 8 && (mode == 1 || mode == 2)) begin
                    if (exp_q.size() == 0) chk(1'b0, "R3 unexpected bus byte", sl_sh, 0);
                    else begin
                        rb = exp_q.pop_front();
                        chk(sl_sh == rb, "R3 bus byte", sl_sh, rb);
                    end
                end
            end else begin
                sl_bit = 0;
                if (mode == 1) begin
                    if (ack_addr) begin
                        mode = sl_sh[0] ? 3 : 2; rd_idx = 0;
                    end else mode = 0;
                end else if (mode == 2) begin
                    if (!ack_data) mode = 0;
                end else if (mode == 3) begin
                    if (sda_v) begin
                        n_mnack++; mode = 0;
                    end else begin
                        n_mack++; rd_idx++;
                    end
                end
            end
        end else if (!scl_v && scl_p) begin
            sl_low = 1'b0;
            rb = 8'hA0 + 8'(rd_idx);
            if (mode == 3 && sl_bit < 8) sl_low = ~rb[7 - sl_bit];
            if (sl_bit == 8 && ((mode == 1 && ack_addr) || (mode == 2 && ack_data)))
                sl_low = 1'b1;
        end
        scl_p = scl_v;
        sda_p = ~(sda_oe_o | sl_low);
    end

    // receive scoreboard monitor
    always @(negedge clk) begin
        logic [7:0] e;
        if (rst_n && rx_valid_o) begin
            if (rxe_q.size() == 0) chk(1'b0, "R11 unexpected rx byte", rx_data_o, 0);
            else begin
                e = rxe_q.pop_front();
                chk(rx_data_o == e, "R11 rx byte", rx_data_o, e);
            end
        end
    end

    // driver helpers
    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask
    task automatic push_tx(input logic [7:0] b);
        tx_mem[wr[3:0]] = b; wr = wr + 5'd1;
    endtask
    task automatic go_pulse();
        @(negedge clk); #1 go_i = 1'b1;
        @(negedge clk); #1 go_i = 1'b0;
    endtask
    task automatic wait_stops(input int target, input string req);
        int t = 0;
        while (n_stop < target && t < 20000) begin
            tick_n(1); t++;
        end
        chk(n_stop >= target, req, n_stop, target);
        tick_n(4);
    endtask
    task automatic wait_ta();
        int t = 0;
        while (!ta_o && t < 1000) begin
            tick_n(1); t++;
        end
    endtask
    task automatic wait_rises(input int target);
        int t = 0;
        while (n_rise < target && t < 20000) begin
            tick_n(1); t++;
        end
    endtask
    task automatic drained(input string req);
        chk(exp_q.size() == 0 && rxe_q.size() == 0, req, exp_q.size() + rxe_q.size(), 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0, r0, st0, m0, k0;
        logic so, do_v;
        int bad;
        tick_n(3);
        // R1 reset state
        chk(!scl_oe_o && !sda_oe_o, "R1 lines released", {scl_oe_o, sda_oe_o}, 0);
        chk(!ta_o && !done_o && !err_o, "R1 status clear", {ta_o, done_o, err_o}, 0);
        chk(!tx_pop_o && !rx_valid_o, "R1 strobes idle", {tx_pop_o, rx_valid_o}, 0);
        rst_n = 1'b1;
        tick_n(3);

        // T1: plain write of 2 bytes; cfg changed after take (R2, R3, R4, R5)
        push_tx(8'h5C); push_tx(8'h93); push_tx(8'hEE);
        exp_q.push_back(8'h54); exp_q.push_back(8'h5C); exp_q.push_back(8'h93);
        cfg_addr_i = 7'h2A; cfg_read_i = 1'b0; cfg_len_i = 8'd2;
        s0 = n_stop; st0 = n_start;
        @(negedge clk); #1 go_i = 1'b1;
        @(negedge clk); #1 go_i = 1'b0;
        chk(ta_o, "R4 ta after take", ta_o, 1);
        cfg_len_i = 8'd5; cfg_read_i = 1'b1; cfg_addr_i = 7'h11;
        wait_stops(s0 + 1, "R10 write ends with stop");
        chk(!ta_o && done_o && !err_o, "R12 done after write", {ta_o, done_o, err_o}, 3'b010);
        chk(wr - rd == 5'd1, "R2 length latched at take", wr - rd, 1);
        tick_n(60);
        chk(n_start == st0 + 1 && !ta_o, "R5 single transfer per pulse", n_start - st0, 1);
        drained("R3 all write bytes seen");
        wr = rd;

        // T2: read 3 bytes from 0x51 (R11)
        cfg_addr_i = 7'h51; cfg_read_i = 1'b1; cfg_len_i = 8'd3;
        exp_q.push_back(8'hA3);
        rxe_q.push_back(8'hA0); rxe_q.push_back(8'hA1); rxe_q.push_back(8'hA2);
        s0 = n_stop; m0 = n_mack; k0 = n_mnack;
        go_pulse();
        wait_stops(s0 + 1, "R11 read ends with stop");
        chk(n_mack - m0 == 2 && n_mnack - k0 == 1, "R11 ack pattern", (n_mack - m0) * 16 + (n_mnack - k0), 8'h21);
        drained("R11 all read bytes seen");

        // T3: write with empty queue, re-arm read, then hold and release (R8, R9, R12)
        cfg_addr_i = 7'h2A; cfg_read_i = 1'b0; cfg_len_i = 8'd1;
        exp_q.push_back(8'h54); exp_q.push_back(8'h3C); exp_q.push_back(8'h55);
        rxe_q.push_back(8'hA0); rxe_q.push_back(8'hA1);
        s0 = n_stop; r0 = n_rstart;
        go_pulse();
        wait_ta();
        cfg_read_i = 1'b1; cfg_len_i = 8'd2;
        go_pulse();
        tick_n(40);
        chk(scl_oe_o && ta_o && wr == rd, "R8 hold with empty queue", {scl_oe_o, ta_o}, 3);
        chk(n_stop == s0, "R8 no stop while holding", n_stop - s0, 0);
        push_tx(8'h3C);
        wait_stops(s0 + 1, "R9 chained transfer ends");
        chk(n_rstart - r0 == 1, "R9 repeated start issued", n_rstart - r0, 1);
        chk(!rs_done, "R12 done low at repeated start", rs_done, 0);
        chk(done_o && !err_o, "R12 done after chain", {done_o, err_o}, 2);
        drained("R9 chained bytes seen");

        // T4: address NACK (R6)
        ack_addr = 1'b0;
        cfg_read_i = 1'b0; cfg_len_i = 8'd1;
        push_tx(8'h11);
        exp_q.push_back(8'h54);
        s0 = n_stop;
        go_pulse();
        wait_stops(s0 + 1, "R6 stop after address NACK");
        chk(err_o && done_o, "R6 error flag", {err_o, done_o}, 3);
        chk(wr - rd == 5'd1, "R6 nothing popped", wr - rd, 1);
        drained("R6 bytes seen");
        wr = rd; ack_addr = 1'b1;

        // T5: data NACK (R7)
        ack_data = 1'b0;
        cfg_len_i = 8'd2;
        push_tx(8'h66); push_tx(8'h77);
        exp_q.push_back(8'h54); exp_q.push_back(8'h66);
        s0 = n_stop;
        go_pulse();
        wait_stops(s0 + 1, "R7 stop after data NACK");
        chk(err_o, "R7 error flag", err_o, 1);
        chk(wr - rd == 5'd1, "R7 later byte kept", wr - rd, 1);
        drained("R7 bytes seen");
        wr = rd; ack_data = 1'b1;

        // T6: re-arm as write gives stop then new transfer (R10, R12 clear)
        cfg_read_i = 1'b0; cfg_len_i = 8'd1;
        exp_q.push_back(8'h54); exp_q.push_back(8'h0F);
        exp_q.push_back(8'h54); exp_q.push_back(8'hF0);
        s0 = n_stop; r0 = n_rstart;
        go_pulse();
        wait_ta();
        chk(!err_o && !done_o, "R12 flags cleared on take", {err_o, done_o}, 0);
        go_pulse();
        push_tx(8'h0F); push_tx(8'hF0);
        wait_stops(s0 + 2, "R10 two separate writes");
        chk(n_rstart == r0, "R10 no repeated start for write re-arm", n_rstart - r0, 0);
        drained("R10 bytes seen");

        // T7a: go in the same cycle as the final acknowledge (R9)
        cfg_read_i = 1'b0; cfg_len_i = 8'd1;
        push_tx(8'h81);
        exp_q.push_back(8'h54); exp_q.push_back(8'h81); exp_q.push_back(8'h55);
        rxe_q.push_back(8'hA0);
        s0 = n_stop; r0 = n_rstart;
        k0 = n_rise;
        go_pulse();
        wait_ta();
        cfg_read_i = 1'b1;
        wait_rises(k0 + 18);
        go_i = 1'b1;
        tick_n(1);
        go_i = 1'b0;
        wait_stops(s0 + 1, "R9 same-cycle re-arm ends");
        chk(n_rstart - r0 == 1 && n_stop - s0 == 1, "R9 same-cycle go chains", n_rstart - r0, 1);
        drained("R9 same-cycle bytes seen");

        // T7b: go one cycle late gives stop then fresh read (R10)
        cfg_read_i = 1'b0;
        push_tx(8'h81);
        exp_q.push_back(8'h54); exp_q.push_back(8'h81); exp_q.push_back(8'h55);
        rxe_q.push_back(8'hA0);
        s0 = n_stop; r0 = n_rstart;
        k0 = n_rise;
        go_pulse();
        wait_ta();
        cfg_read_i = 1'b1;
        wait_rises(k0 + 18);
        tick_n(1);
        go_i = 1'b1;
        tick_n(1);
        go_i = 1'b0;
        wait_stops(s0 + 2, "R10 late go runs two transfers");
        chk(n_rstart == r0, "R10 late go no repeated start", n_rstart - r0, 0);
        drained("R10 late go bytes seen");

        // T8: phase strobe gating (R13)
        cfg_read_i = 1'b0; cfg_len_i = 8'd2;
        push_tx(8'h12); push_tx(8'h34);
        exp_q.push_back(8'h54); exp_q.push_back(8'h12); exp_q.push_back(8'h34);
        s0 = n_stop;
        k0 = n_rise;
        go_pulse();
        wait_rises(k0 + 5);
        tick_i = 1'b0;
        so = scl_oe_o; do_v = sda_oe_o;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            tick_n(1);
            if (scl_oe_o != so || sda_oe_o != do_v) bad++;
        end
        chk(bad == 0, "R13 frozen without tick", bad, 0);
        tick_i = 1'b1;
        wait_stops(s0 + 1, "R13 transfer resumes");
        drained("R13 bytes seen");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule